// File: doc/BRIEF.md
# Capture-Compare Timer Channel with Guarded Status Flags

This block is a single timer channel. It holds a free-running up-counter and four general registers, named A, B, C and D. Each general register works either as an input-capture register or as an output-compare register. In capture mode, a trigger copies the counter value into the register. In compare mode, the register is checked against the counter each time the counter steps. A PWM mode turns B, C and D into compare registers. In that mode, D acts as the synchronising register, and B and C report no events.

Every register has a status flag, and each flag has an enable bit. The interrupt request is raised while any enabled flag is set. Software clears a flag in two steps. First it reads the flag register and sees the bit at 1. Then it writes 0 to that bit. A stray write of 0 therefore cannot lose an event. The capture trigger for all four registers can come from another channel's compare-match pulse. Such captures still load the register, but they leave the flag alone.

Top module: `tmr_capcmp_flags`

## Requirements
- R1: After reset, the counter, the four general registers, the mode register, the flag register and the enable register all read 0, and `irq` is 0.
- R2: The counter rises by 1 (wrapping) at every clock edge where `cnt_en` is 1. A bus write to address 0 loads the counter instead and wins over the increment.
- R3: When register i (A=1, B=2, C=3, D=4 on the bus) has mode bit i set (address 5, bits 3..0 for A..D; 1 selects capture), its trigger copies the counter into it and sets flag i (address 6, bits 3..0 for A..D) at the same clock edge.
- R4: While `xtrig_sel` is 1, the trigger of every capture register is `xchan_match` and `cap_trig` is ignored. Such a capture still copies the counter, but it does not set the flag.
- R5: A register in compare mode sets its flag at the edge after the edge where the counter stepped (by increment) to a value equal to the register. It does not set the flag while the counter holds, after a counter load, or when the register is written to equal a held counter.
- R6: While PWM mode is on (address 5, bit 4), registers B, C and D behave as compare registers whatever their mode bits say. The flag for D sets on a match. The flags for B and C never set. Register A keeps its programmed mode.
- R7: Writing 0 to a flag bit clears it only if a read of the flag register has returned 1 in that bit since the last write to the flag register. Writing 1 has no effect. Every write to the flag register uses up all pending read permissions.
- R8: If a flag's set event occurs in the same cycle as a valid clear of that flag, the flag stays 1.
- R9: `irq` is 1 exactly while some flag bit and its enable bit (address 7, bits 3..0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter increment enable |
| cap_trig | input | 4 | Per-register capture trigger pulses, bit 0 = A |
| xtrig_sel | input | 1 | Select the other channel's compare match as capture trigger |
| xchan_match | input | 1 | Compare-match pulse from the other channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Captures are tried with a held counter under both trigger sources. This separates the register copy from the flag set, and shows that `cap_trig` is ignored while the cross-channel source is selected. Compare matches are tried with a counter that passes the value, with a counter that holds at the value, and with a register written to equal a held counter. This shows that a match counts once per step. The clear sequence is tried without a prior read, with a write of 1, with a proper read-then-zero, and with a set event in the same cycle as the clear. PWM runs a counter across three staged register values, so that only D's flag rises.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned NUM_GR = 4;
  localparam int unsigned IDX_A  = 0;
  localparam int unsigned IDX_B  = 1;
  localparam int unsigned IDX_C  = 2;
  localparam int unsigned IDX_D  = 3;

  typedef enum logic [2:0] {
    ADR_CNT  = 3'd0,
    ADR_GRA  = 3'd1,
    ADR_GRB  = 3'd2,
    ADR_GRC  = 3'd3,
    ADR_GRD  = 3'd4,
    ADR_MODE = 3'd5,
    ADR_FLAG = 3'd6,
    ADR_IEN  = 3'd7
  } reg_addr_e;

  // PWM mode mutes the flags of registers B and C
  function automatic logic flag_allowed(input logic pwm, input int unsigned idx);
    return !(pwm && (idx == IDX_B || idx == IDX_C));
  endfunction

  // In PWM mode every register except A is forced to compare
  function automatic logic capture_mode(input logic mode_bit, input logic pwm,
                                        input int unsigned idx);
    return mode_bit && !(pwm && idx != IDX_A);
  endfunction

  // set wins over clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             stepped
);

  logic [CNT_W-1:0] cnt_q;
  logic             step_q;

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      if (load)        cnt_q <= load_val;
      else if (inc_en) cnt_q <= cnt_inc(cnt_q);
      step_q <= inc_en && !load;
    end
  end

  assign cnt     = cnt_q;
  assign stepped = step_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && inc_en && !load) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && load) |-> cnt_q == $past(load_val)); // R2

endmodule

// File: rtl/tmr_greg.sv
module tmr_greg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_ev,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] gr
);

  logic [CNT_W-1:0] gr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      gr_q <= '0;
    else if (cap_ev) gr_q <= cnt;
    else if (wr_en)  gr_q <= wdata;
  end

  assign gr = gr_q;

  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cap_ev) |-> gr_q == $past(cnt)); // R3

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);

  logic [N-1:0] flag_q;
  logic [N-1:0] arm_q;
  logic [N-1:0] clr_vec;

  assign clr_vec = wr_stb ? (arm_q & ~wbits) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++)
        flag_q[i] <= tmr_pkg::flag_next(flag_q[i], set_vec[i], clr_vec[i]);
      if (wr_stb)      arm_q <= '0;
      else if (rd_stb) arm_q <= arm_q | flag_q;
    end
  end

  assign flags = flag_q;

  for (genvar g = 0; g < int'(N); g++) begin : g_chk
    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> $past(wr_stb && arm_q[g] && !wbits[g])); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && set_vec[g]) |-> flag_q[g]); // R8
    AST_RISE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[g]) |-> $past(set_vec[g])); // R3
  end

endmodule

// File: rtl/tmr_capcmp_flags.sv
module tmr_capcmp_flags #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [3:0]       cap_trig,
  input  logic             xtrig_sel,
  input  logic             xchan_match,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  import tmr_pkg::*;

  localparam int unsigned NG     = NUM_GR;
  localparam int unsigned MODE_W = NG + 1;
  localparam int unsigned PAD_M  = CNT_W - MODE_W;
  localparam int unsigned PAD_F  = CNT_W - NG;

  reg_addr_e         addr;
  logic              wr_stb, rd_stb;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_step;
  logic [CNT_W-1:0]  gr [NG];
  logic [NG-1:0]     mode_q, ien_q;
  logic              pwm_q;
  logic [NG-1:0]     trig, cap_ev, cmp_ev, set_vec, flags;

  function automatic logic cmp_hit(input logic step, input logic [CNT_W-1:0] a,
                                   input logic [CNT_W-1:0] b);
    return step && (a == b);
  endfunction

  assign addr   = reg_addr_e'(bus_addr);
  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pwm_q  <= 1'b0;
      ien_q  <= '0;
    end else if (wr_stb) begin
      if (addr == ADR_MODE) begin
        mode_q <= bus_wdata[NG-1:0];
        pwm_q  <= bus_wdata[NG];
      end
      if (addr == ADR_IEN) ien_q <= bus_wdata[NG-1:0];
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (cnt_en),
    .load     (wr_stb && addr == ADR_CNT),
    .load_val (bus_wdata),
    .cnt      (cnt),
    .stepped  (cnt_step)
  );

  for (genvar g = 0; g < int'(NG); g++) begin : g_reg
    logic capm;
    assign capm       = capture_mode(mode_q[g], pwm_q, g);
    assign trig[g]    = xtrig_sel ? xchan_match : cap_trig[g];
    assign cap_ev[g]  = capm && trig[g];
    assign cmp_ev[g]  = !capm && cmp_hit(cnt_step, cnt, gr[g]);
    assign set_vec[g] = ((cap_ev[g] && !xtrig_sel) || cmp_ev[g]) && flag_allowed(pwm_q, g);

    tmr_greg #(.CNT_W(CNT_W)) u_gr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_ev (cap_ev[g]),
      .wr_en  (wr_stb && bus_addr == 3'(g + 1)),
      .wdata  (bus_wdata),
      .cnt    (cnt),
      .gr     (gr[g])
    );

    AST_XTRIG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (xtrig_sel && cap_ev[g] && !flags[g]) |=> !flags[g]); // R4
    AST_HOLD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_step && !cap_ev[g] && !flags[g]) |=> !flags[g]); // R5
  end

  tmr_flags #(.N(NG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd_stb  (rd_stb && addr == ADR_FLAG),
    .wr_stb  (wr_stb && addr == ADR_FLAG),
    .wbits   (bus_wdata[NG-1:0]),
    .flags   (flags)
  );

  assign irq = |(flags & ien_q);

  always_comb begin
    case (addr)
      ADR_CNT:  bus_rdata = cnt;
      ADR_GRA:  bus_rdata = gr[IDX_A];
      ADR_GRB:  bus_rdata = gr[IDX_B];
      ADR_GRC:  bus_rdata = gr[IDX_C];
      ADR_GRD:  bus_rdata = gr[IDX_D];
      ADR_MODE: bus_rdata = {{PAD_M{1'b0}}, pwm_q, mode_q};
      ADR_FLAG: bus_rdata = {{PAD_F{1'b0}}, flags};
      ADR_IEN:  bus_rdata = {{PAD_F{1'b0}}, ien_q};
      default:  bus_rdata = '0;
    endcase
  end

  AST_PWM_BC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_q && flags[2:1] == 2'b00) |=> flags[2:1] == 2'b00); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R9

endmodule

// File: tb/tmr_capcmp_flags_tb_top.sv
module tmr_capcmp_flags_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [3:0]  cap_trig = '0;
  logic        xtrig_sel = 1'b0;
  logic        xchan_match = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd6;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tmr_capcmp_flags #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_trig(cap_trig),
    .xtrig_sel(xtrig_sel), .xchan_match(xchan_match), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_cnt;
  logic [15:0] m_gr [4];
  logic        m_step, m_pwm;
  logic [3:0]  m_mode, m_flag, m_arm, m_ien;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_step = 0; m_pwm = 0; m_mode = 0; m_flag = 0; m_arm = 0; m_ien = 0;
      for (int i = 0; i < 4; i++) m_gr[i] = 0;
    end else begin
      logic [3:0]  nf;
      logic [15:0] ng [4];
      for (int i = 0; i < 4; i++) begin
        bit capm, trg, hit, setb, clrb;
        capm = m_mode[i] && !(m_pwm && i > 0);
        trg  = xtrig_sel ? xchan_match : cap_trig[i];
        hit  = !capm && m_step && (m_cnt == m_gr[i]);
        setb = ((capm && trg && !xtrig_sel) || hit) && !(m_pwm && (i == 1 || i == 2));
        clrb = bus_sel && bus_wr && bus_addr == 6 && m_arm[i] && !bus_wdata[i];
        nf[i] = setb ? 1'b1 : (clrb ? 1'b0 : m_flag[i]);
        if (capm && trg) ng[i] = m_cnt;
        else if (bus_sel && bus_wr && bus_addr == 3'(i + 1)) ng[i] = bus_wdata;
        else ng[i] = m_gr[i];
      end
      if (bus_sel && !bus_wr && bus_addr == 6) m_arm = m_arm | m_flag;
      if (bus_sel && bus_wr && bus_addr == 6) m_arm = 0;
      m_flag = nf;
      for (int i = 0; i < 4; i++) m_gr[i] = ng[i];
      if (bus_sel && bus_wr && bus_addr == 5) begin m_mode = bus_wdata[3:0]; m_pwm = bus_wdata[4]; end
      if (bus_sel && bus_wr && bus_addr == 7) m_ien = bus_wdata[3:0];
      if (bus_sel && bus_wr && bus_addr == 0) begin m_cnt = bus_wdata; m_step = 0; end
      else begin m_step = cnt_en; if (cnt_en) m_cnt = m_cnt + 16'd1; end
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1, 3'd2, 3'd3, 3'd4: return m_gr[a - 1];
      3'd5: return {11'd0, m_pwm, m_mode};
      3'd6: return {12'd0, m_flag};
      default: return {12'd0, m_ien};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3, 3'd4: return "R3";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      check(bus_rdata == m_read(bus_addr), tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      check(irq == |(m_flag & m_ien), "R9", 16'(irq), 16'(|(m_flag & m_ien)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 3'd6; bus_wdata = 0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #3;
    check(bus_rdata == exp, tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0; bus_addr = 3'd6;
  endtask

  task automatic pulse_cap(input logic [3:0] b);
    @(negedge clk); cap_trig = b;
    @(negedge clk); cap_trig = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    ticks(3);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 16'd0, "R1");
    check(irq == 1'b0, "R1", 16'(irq), 16'd0);

    // R2 counting and load priority
    wr(3'd0, 16'd100);
    cnt_en = 1; ticks(5); cnt_en = 0;
    expect_rd(3'd0, 16'd105, "R2");
    cnt_en = 1; wr(3'd0, 16'd7); cnt_en = 0;
    expect_rd(3'd0, 16'd7, "R2");

    // R3 capture on A
    wr(3'd5, 16'h0001);
    pulse_cap(4'b0001);
    expect_rd(3'd1, 16'd7, "R3");
    expect_rd(3'd6, 16'h1, "R3");

    // R7 clear sequence
    wr(3'd6, 16'hF);                 // consumes permission, writing 1 does nothing
    expect_rd(3'd6, 16'h1, "R7");    // read arms again
    wr(3'd6, 16'hF);                 // consume
    wr(3'd6, 16'h0);                 // no permission: must stay
    expect_rd(3'd6, 16'h1, "R7");
    wr(3'd6, 16'h0);                 // permitted clear
    expect_rd(3'd6, 16'h0, "R7");

    // R8 set beats clear
    pulse_cap(4'b0001);
    expect_rd(3'd6, 16'h1, "R8");
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd6; bus_wdata = 0; cap_trig = 4'b0001;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; cap_trig = 0;
    expect_rd(3'd6, 16'h1, "R8");
    wr(3'd6, 16'h0);
    expect_rd(3'd6, 16'h0, "R7");

    // R4 cross-channel trigger
    xtrig_sel = 1;
    wr(3'd0, 16'd55);
    @(negedge clk); xchan_match = 1; @(negedge clk); xchan_match = 0;
    expect_rd(3'd1, 16'd55, "R4");
    wr(3'd0, 16'd60);
    pulse_cap(4'b0001);              // ignored while cross source selected
    expect_rd(3'd1, 16'd55, "R4");
    expect_rd(3'd6, 16'h0, "R4");
    xtrig_sel = 0;

    // R9 interrupt masking
    pulse_cap(4'b0001);              // GRA <= 60, flag A
    wr(3'd7, 16'h1);
    #3; check(irq == 1'b1, "R9", 16'(irq), 16'd1);
    wr(3'd7, 16'h2);
    #3; check(irq == 1'b0, "R9", 16'(irq), 16'd0);
    expect_rd(3'd6, 16'h1, "R9");
    wr(3'd6, 16'h0);
    wr(3'd7, 16'h0);

    // R5 compare once per step
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'd55);
    wr(3'd2, 16'd63);
    cnt_en = 1; ticks(3); cnt_en = 0;   // 60 -> 63
    expect_rd(3'd6, 16'h2, "R5");
    wr(3'd6, 16'h0);
    ticks(4);
    expect_rd(3'd6, 16'h0, "R5");       // counter held at match
    wr(3'd1, 16'd63);
    ticks(2);
    expect_rd(3'd6, 16'h0, "R5");       // written equal to held counter

    // R6 PWM mode
    wr(3'd5, 16'h001E);
    wr(3'd2, 16'd65);
    wr(3'd3, 16'd66);
    wr(3'd4, 16'd67);
    pulse_cap(4'b1110);
    expect_rd(3'd2, 16'd65, "R6");
    expect_rd(3'd6, 16'h0, "R6");
    wr(3'd0, 16'd64);
    cnt_en = 1; ticks(4); cnt_en = 0;   // 64 -> 68
    ticks(2);
    expect_rd(3'd6, 16'h8, "R6");
    expect_rd(3'd0, 16'd68, "R2");

    ticks(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule